// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle Preamble

This block is the transmit half of a full-duplex asynchronous NRZ serial port. A modulo divider on the bus clock makes a sampling tick at sixteen times the baud rate. The tick is published so that a receiver can share it. A shift register clocked at one bit per sixteen ticks sends frames of 10 bits (8 data bits) or 11 bits (9 data bits). Data bits go out least-significant bit first, framed by a low start bit and a high stop bit.

Software writes words into a one-entry holding buffer. The buffer hands its word to the shifter at the tick that ends the current frame, so consecutive words go out back to back with no gap. When the transmitter is switched on, it first sends one whole frame of idle (all ones), and only then any data. Switching it off lets the frame in progress finish, and then holds the line high.

Top module: `async_tx`

## Requirements
- R1: With a divisor D from 1 to 8191, `tick16_o` pulses for one clock cycle once every D clock cycles (exactly 100 pulses in any 300 consecutive cycles for D = 3).
- R2: With a divisor of zero, no tick is produced and `txd_o` does not change.
- R3: A low-to-high change of `tx_en_i` sends one idle frame (all ones, 10 bits in 8-bit mode) before any data, including a word already waiting in the buffer. For D = 2, the first start bit begins 320 to 325 cycles after the enable rises.
- R4: After the preamble and any buffered data, `txd_o` stays high until a new word is written.
- R5: With `nine_bit_i` = 0, a frame is a start bit (0), `wr_data_i[7:0]` LSB first, then a stop bit (1). Each bit lasts 16 ticks, and `txd_o` changes only in the cycle after a tick.
- R6: With `nine_bit_i` = 1, a frame is a start bit, `wr_data_i[8:0]` LSB first, then a stop bit: 11 bits. The mode is captured when a frame is loaded.
- R7: A word written while a frame is shifting starts exactly at the end of that frame's stop bit (start bits 160 ticks apart in 8-bit mode). The buffer only drains on a tick.
- R8: `buf_empty_o` falls in the cycle after an accepted write, and rises when the word moves into the shift register.
- R9: `tx_done_o` is high exactly when the shifter is idle, the buffer is empty and no preamble is pending. The line is then high.
- R10: A write while `buf_empty_o` is low is ignored: the word is never transmitted.
- R11: Clearing `tx_en_i` lets the current frame finish. After that the line stays high and a buffered word stays held, unsent, until the transmitter is enabled again.
- R12: Reset drives `txd_o` high, empties the buffer, idles the shifter, and sets `buf_empty_o` and `tx_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable; rising edge queues the idle preamble |
| nine_bit_i | input | 1 | 0: 8 data bits, 1: 9 data bits |
| divisor_i | input | 13 | Baud divisor, 0 stops the generator |
| wr_i | input | 1 | Write strobe for the holding buffer |
| wr_data_i | input | 9 | Word to transmit |
| txd_o | output | 1 | Serial line, idle high |
| buf_empty_o | output | 1 | Holding buffer can accept a word |
| tx_done_o | output | 1 | Shifter idle and nothing queued |
| tick16_o | output | 1 | Sampling tick at 16x baud |

## Verification
Most internal faults show up directly at the serial line. A wrong divider or sub-bit count stretches or shrinks every bit, and a frame decoded at mid-bit then reads a shifted word within a single frame time. A wrong shift or framing order gives a wrong word at the first stop bit. If the preamble flag is lost or the buffer hand-off is mistimed, the first start bit lands hundreds of cycles early, or a gap opens between back-to-back frames, and both are measured in cycles. A corrupted buffer-full state shows on the next cycle through `buf_empty_o`, or later as an extra frame from a write that should have been dropped.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  localparam int DIV_W_DEF  = 13;
  localparam int DATA_W_DEF = 9;
  localparam int TICKS_DEF  = 16;
endpackage

// File: rtl/async_tx_baud.sv
module async_tx_baud #(
  parameter int DIV_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             run;

  assign run    = |div_i;
  assign tick_o = run && (cnt_q >= div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run || tick_o)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/async_tx_buf.sv
module async_tx_buf #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (take_i) begin
      full_o <= 1'b0;
    end else if (wr_i && !full_o) begin
      full_o <= 1'b1;
      data_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift #(
  parameter int FRAME_W = 11,
  parameter int TICKS   = 16,
  localparam int LEN_W  = $clog2(FRAME_W + 1),
  localparam int SUB_W  = $clog2(TICKS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_frame_i,
  input  logic [LEN_W-1:0]   load_len_i,
  output logic               free_o,
  output logic               busy_o,
  output logic               txd_o
);
  logic [FRAME_W-1:0] sr_q;
  logic [LEN_W-1:0]   left_q;
  logic [SUB_W-1:0]   sub_q;
  logic               busy_q;
  logic               bit_end, last_bit;

  assign bit_end  = busy_q && (sub_q == SUB_W'(TICKS - 1));
  assign last_bit = bit_end && (left_q == LEN_W'(1));
  // shifter accepts a frame on the tick that ends the previous one
  assign free_o   = tick_i && (!busy_q || last_bit);
  assign busy_o   = busy_q;
  assign txd_o    = busy_q ? sr_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
      busy_q <= 1'b0;
    end else if (tick_i) begin
      if (load_i) begin
        sr_q   <= load_frame_i;
        left_q <= load_len_i;
        sub_q  <= '0;
        busy_q <= 1'b1;
      end else if (last_bit) begin
        sr_q   <= '1;
        sub_q  <= '0;
        busy_q <= 1'b0;
      end else if (busy_q) begin
        sub_q <= sub_q + SUB_W'(1);
        if (bit_end) begin
          sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
          left_q <= left_q - LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DIV_W  = DIV_W_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int TICKS  = TICKS_DEF,
  localparam int FRAME_W = DATA_W + 2,
  localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              nine_bit_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              txd_o,
  output logic              buf_empty_o,
  output logic              tx_done_o,
  output logic              tick16_o
);
  logic              en_q, pre_q;
  logic              buf_full, free, busy, load, take;
  logic [DATA_W-1:0] buf_data;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]  frame_len;

  async_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .div_i(divisor_i), .tick_o(tick16_o)
  );

  async_tx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .wr_i, .wr_data_i, .take_i(take),
    .full_o(buf_full), .data_o(buf_data)
  );

  // en_q gates loads so a rising enable always queues the preamble first
  assign load = free && tx_en_i && en_q && (pre_q || buf_full);
  assign take = load && !pre_q;

  always_comb begin
    frame_len = nine_bit_i ? LEN_W'(FRAME_W) : LEN_W'(FRAME_W - 1);
    if (pre_q)           frame = '1;
    else if (nine_bit_i) frame = {1'b1, buf_data, 1'b0};
    else                 frame = {2'b11, buf_data[DATA_W-2:0], 1'b0};
  end

  async_tx_shift #(.FRAME_W(FRAME_W), .TICKS(TICKS)) u_shift (
    .clk_i, .rst_ni, .tick_i(tick16_o), .load_i(load),
    .load_frame_i(frame), .load_len_i(frame_len),
    .free_o(free), .busy_o(busy), .txd_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      pre_q <= 1'b0;
    end else begin
      en_q <= tx_en_i;
      if (!tx_en_i)   pre_q <= 1'b0;
      else if (!en_q) pre_q <= 1'b1;
      else if (load)  pre_q <= 1'b0;
    end
  end

  assign buf_empty_o = !buf_full;
  assign tx_done_o   = !busy && !buf_full && !pre_q;
endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk #(
  parameter int DIV_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_en_i,
  input logic [DIV_W-1:0] divisor_i,
  input logic             wr_i,
  input logic             txd_o,
  input logic             buf_empty_o,
  input logic             tx_done_o,
  input logic             tick16_o
);
  // R2
  off_line_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divisor_i == '0) |=> $stable(txd_o));
  // R5
  line_moves_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick16_o |=> $stable(txd_o));
  // R7
  drain_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!buf_empty_o && !tick16_o) |=> !buf_empty_o);
  // R8
  write_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && buf_empty_o) |=> !buf_empty_o);
  // R9
  done_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> txd_o);
  // R11
  off_stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && tx_done_o) |=> txd_o);
endmodule

bind async_tx async_tx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .divisor_i(divisor_i),
  .wr_i(wr_i), .txd_o(txd_o), .buf_empty_o(buf_empty_o),
  .tx_done_o(tx_done_o), .tick16_o(tick16_o)
);

// File: tb/async_tx_tb.sv
module async_tx_tb;
  typedef struct packed { logic nine; logic [8:0] d; } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, nine = 1'b0, wr = 1'b0;
  logic [12:0] div = '0;
  logic [8:0]  wdata = '0;
  logic        txd, bempty, done, tick;

  int     errors = 0, checks = 0;
  longint cyc = 0;
  int     bit_len = 32;
  item_t  exp_q[$];
  longint start_cyc[$];
  bit     finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(en), .nine_bit_i(nine),
    .divisor_i(div), .wr_i(wr), .wr_data_i(wdata), .txd_o(txd),
    .buf_empty_o(bempty), .tx_done_o(done), .tick16_o(tick)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic raw_write(input logic [8:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic send(input logic n, input logic [8:0] d);
    exp_q.push_back('{nine: n, d: d});
    raw_write(d);
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  // monitor: decode frames at mid-bit, compare against scoreboard
  initial begin : monitor
    logic  prev;
    item_t e;
    logic [8:0] got;
    logic  s, stp;
    int    nb;
    bit    unexp;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !txd) begin
        start_cyc.push_back(cyc);
        unexp = (exp_q.size() == 0);
        e = unexp ? '0 : exp_q.pop_front();
        nb = e.nine ? 9 : 8;
        repeat (bit_len / 2) @(negedge clk);
        s = txd;
        got = '0;
        for (int i = 0; i < nb; i++) begin
          repeat (bit_len) @(negedge clk);
          got[i] = txd;
        end
        repeat (bit_len) @(negedge clk);
        stp = txd;
        // R5 (8-bit) / R6 (9-bit) frame content; R10 no unexpected frame
        check(!unexp && s == 1'b0 && stp == 1'b1 && got == e.d,
              unexp ? "R10 unexpected frame" : (e.nine ? "R6 frame" : "R5 frame"),
              {s, stp, got}, {2'b01, e.d});
      end
      prev = txd;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int     n, n0;
    longint t0;
    bit     high;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(txd == 1'b1, "R12 txd", txd, 1);
    check(bempty == 1'b1, "R12 buf_empty", bempty, 1);
    check(done == 1'b1, "R12 tx_done", done, 1);
    rst_n = 1'b1;

    // R2 divisor zero: no ticks, line idle even when enabled
    en = 1'b1;
    n = 0; high = 1'b1;
    repeat (500) begin @(negedge clk); n += tick; high &= txd; end
    check(n == 0, "R2 ticks", n, 0);
    check(high, "R2 line", high, 1);
    en = 1'b0;

    // R1 tick rate for D=3
    @(negedge clk); div = 13'd3;
    @(negedge clk);
    n = 0;
    repeat (300) begin @(negedge clk); n += tick; end
    check(n == 100, "R1 tick count", n, 100);

    // R3 preamble before a word written at enable time
    div = 13'd2; bit_len = 32;
    repeat (10) @(negedge clk);
    exp_q.push_back('{nine: 1'b0, d: 9'h0A5});
    en = 1'b1; wr = 1'b1; wdata = 9'h0A5;
    t0 = cyc;
    @(negedge clk); wr = 1'b0;
    while (txd) @(negedge clk);
    check(cyc - t0 >= 320 && cyc - t0 <= 325, "R3 preamble delay", cyc - t0, 320);
    wait_done();

    // R4 idle after transmission
    high = 1'b1;
    repeat (1000) begin @(negedge clk); high &= txd; end
    check(high && done, "R4 idle high", high, 1);

    // R8/R9 flags on write; R7 back-to-back; R10 ignored write
    n0 = start_cyc.size();
    send(1'b0, 9'h03C);
    check(bempty == 1'b0, "R8 buf_empty after write", bempty, 0);
    check(done == 1'b0, "R9 tx_done after write", done, 0);
    while (!bempty) @(negedge clk);
    send(1'b0, 9'h0C3);
    raw_write(9'h0FF);
    wait_done();
    repeat (40) @(negedge clk);
    check(start_cyc.size() == n0 + 2, "R10 frame count", start_cyc.size(), n0 + 2);
    if (start_cyc.size() >= n0 + 2)
      check(start_cyc[n0+1] - start_cyc[n0] == 320, "R7 frame spacing",
            start_cyc[n0+1] - start_cyc[n0], 320);
    check(done && bempty && txd, "R9 idle flags", {done, bempty, txd}, 3'b111);

    // R6 nine-bit frames
    nine = 1'b1;
    send(1'b1, 9'h15A);
    while (!bempty) @(negedge clk);
    send(1'b1, 9'h081);
    wait_done();
    repeat (40) @(negedge clk);
    nine = 1'b0;

    // R11 disable mid-frame
    n0 = start_cyc.size();
    send(1'b0, 9'h055);
    while (txd) @(negedge clk);
    repeat (50) @(negedge clk);
    raw_write(9'h066);
    check(bempty == 1'b0, "R11 buffer held", bempty, 0);
    en = 1'b0;
    high = 1'b1;
    repeat (400) @(negedge clk);
    repeat (1500) begin @(negedge clk); high &= txd; end
    check(start_cyc.size() == n0 + 1, "R11 frame finished once", start_cyc.size(), n0 + 1);
    check(high, "R11 line high", high, 1);
    check(bempty == 1'b0 && done == 1'b0, "R11 word kept", {bempty, done}, 0);

    // re-enable: preamble then held word
    exp_q.push_back('{nine: 1'b0, d: 9'h066});
    en = 1'b1;
    wait_done();
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R3 all queued words sent", exp_q.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule